// File: doc/BRIEF.md
# SPI Serial Clock Prescaler with Two Divisor Encodings

This block turns the core clock into a stream of single-cycle toggle strobes that a downstream shift engine uses to flip the serial clock. The division ratio comes from an 8-bit configuration byte. A select input chooses how that byte is read. The compact encoding gives even ratios between 4 and 30. The wide encoding multiplies a 4-bit base by a power of two, which reaches ratios up to 1920. Any byte that does not give a usable ratio raises an invalid flag, and while the flag is set the block issues no strobes.

The block is controlled by a transfer-active input. While that input is low, the block is in `ST_IDLE`. In that state it re-decodes the configuration every cycle and keeps no count running. On the first active cycle it latches the setting and moves to one of two states. It goes to `ST_RUN` when the setting is usable and to `ST_HALT` when it is not. It stays in that state until the transfer-active input falls, which returns it to `ST_IDLE`. The three transitions are:

- `IDLE->RUN`: the transfer starts with a valid setting.
- `IDLE->HALT`: the transfer starts with an invalid setting.
- `RUN/HALT->IDLE`: the transfer ends.

In `ST_RUN` a half-period counter produces one strobe at the end of each half period. For odd ratios the first half period is the longer one, so a full period always lasts exactly the ratio in core cycles.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While reset is held, `sclk_tick` and `cfg_invalid` are both 0.
- R2: With `ext_mode`=0, the field `cfg_byte[4:0]` = F in the range 0x12..0x1F selects the ratio 2*(F-16). Bits 7:5 have no effect on the ratio.
- R3: With `ext_mode`=1, the ratio is B*2^E, where B is `cfg_byte[3:0]` and E is {`cfg_byte[7]`,`cfg_byte[6]`,`cfg_byte[4]`} (bit 7 is the exponent MSB). Bit 5 has no effect.
- R4: A setting whose ratio is below 4 is invalid. This covers B=0, any compact field below 0x12, and any wide product below 4. In `ST_IDLE`, `cfg_invalid` shows the validity of the current setting one cycle after it is applied. A transfer started with an invalid setting produces no strobe.
- R5: Take the rising edge on which `xfer_active` is first sampled high as edge 0. Strobes are then seen after edges h, d, d+h, 2d and so on, where d is the ratio and h=ceil(d/2). The spacing between strobes alternates h and floor(d/2).
- R6: For an even ratio, all strobe spacings are equal to d/2.
- R7: A change to `cfg_byte` or `ext_mode` while `xfer_active` stays high changes neither the strobe spacing nor `cfg_invalid` until the transfer ends.
- R8: One cycle after `xfer_active` is sampled low, `sclk_tick` is 0, and it stays 0 while the input stays low.
- R9: The extreme wide settings behave as stated. B=15 with E=7 gives ratio 1920 (half period 960). B=2 with E=1 gives 4, which is valid. B=3 with E=0 gives 3, which is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | High while a transfer runs; the setting is frozen while high |
| ext_mode | input | 1 | 0 = compact even-ratio encoding, 1 = wide base-times-power-of-two encoding |
| cfg_byte | input | 8 | Divisor configuration byte |
| sclk_tick | output | 1 | Single-cycle strobe at each serial clock edge |
| cfg_invalid | output | 1 | Latched setting cannot produce a ratio of at least 4 |

## Verification
The hardest situation to reach from the ports is a setting that changes in the middle of a transfer. The new value must be provably ignored, which means the strobe spacing and the flag must still match the old ratio, and this only shows over several periods. The stimulus handles this by writing a different byte and a different encoding right after the first strobe is seen, then measuring the following gaps against the original ratio. A second hard case is the odd-ratio asymmetry. Random bytes in the wide encoding often give odd ratios, and each run is measured over two full periods so that both the long and the short half are observed.

// File: rtl/spipre_pkg.sv
package spipre_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } pre_state_e;
endpackage

// File: rtl/spipre_decode.sv
module spipre_decode #(
    parameter int CFG_W    = 8,
    parameter int SPR_W    = 4,
    parameter int EXP_W    = 3,
    parameter int LEG_W    = 5,
    parameter int LEG_BASE = 16,
    parameter int MIN_DIV  = 4,
    parameter int DIV_W    = SPR_W + (1 << EXP_W) - 1
) (
    input  logic             ext_mode,
    input  logic [CFG_W-1:0] cfg,
    output logic [DIV_W-1:0] div,
    output logic             bad
);
    logic [LEG_W-1:0] leg_field;
    logic [DIV_W-1:0] leg_div;
    logic             leg_bad;
    logic [SPR_W-1:0] base_val;
    logic [EXP_W-1:0] exp_val;
    logic [DIV_W-1:0] ext_div;
    logic             ext_bad;

    always_comb begin
        // compact form: field holds base offset plus half the ratio
        leg_field = cfg[LEG_W-1:0];
        leg_div   = (DIV_W'(leg_field) - DIV_W'(LEG_BASE)) << 1;
        leg_bad   = (leg_field < LEG_W'(LEG_BASE)) || (leg_div < DIV_W'(MIN_DIV));
        // wide form: exponent bits sit on both sides of the untouched bit 5
        base_val  = cfg[SPR_W-1:0];
        exp_val   = {cfg[7:6], cfg[4]};
        ext_div   = DIV_W'(base_val) << exp_val;
        ext_bad   = (base_val == '0) || (ext_div < DIV_W'(MIN_DIV));
        div       = ext_mode ? ext_div : leg_div;
        bad       = ext_mode ? ext_bad : leg_bad;
    end
endmodule

// File: rtl/spipre_fsm.sv
module spipre_fsm
    import spipre_pkg::*;
#(
    parameter int DIV_W   = 11,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic [DIV_W-1:0] div_in,
    input  logic             bad_in,
    output logic             tick,
    output logic             invalid
);
    pre_state_e       state_q, state_d;
    logic [DIV_W-1:0] div_q;
    logic             bad_q;
    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic             tick_q;
    logic [DIV_W-1:0] half_long, half_short, limit;
    logic             wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (xfer_active) state_d = bad_in ? ST_HALT : ST_RUN;
            ST_RUN:  if (!xfer_active) state_d = ST_IDLE;
            ST_HALT: if (!xfer_active) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // half-period selection and strobe condition
    always_comb begin
        half_long  = (div_q + DIV_W'(1)) >> 1;
        half_short = div_q >> 1;
        limit      = phase_q ? half_short : half_long;
        wrap       = (state_q == ST_RUN) && xfer_active && (cnt_q == limit - DIV_W'(1));
    end

    // datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(MIN_DIV);
            bad_q   <= 1'b0;
            cnt_q   <= '0;
            phase_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            tick_q <= wrap;
            if (state_q == ST_IDLE) begin
                div_q <= div_in;
                bad_q <= bad_in;
            end
            if ((state_q == ST_RUN) && xfer_active) begin
                if (wrap) begin
                    cnt_q   <= '0;
                    phase_q <= ~phase_q;
                end else begin
                    cnt_q <= cnt_q + DIV_W'(1);
                end
            end else begin
                cnt_q   <= '0;
                phase_q <= 1'b0;
            end
        end
    end

    assign tick    = tick_q;
    assign invalid = bad_q;
endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
    parameter int CFG_W   = 8,
    parameter int SPR_W   = 4,
    parameter int EXP_W   = 3,
    parameter int MIN_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             ext_mode,
    input  logic [CFG_W-1:0] cfg_byte,
    output logic             sclk_tick,
    output logic             cfg_invalid
);
    localparam int DIV_W = SPR_W + (1 << EXP_W) - 1;

    logic [DIV_W-1:0] dec_div;
    logic             dec_bad;

    spipre_decode #(
        .CFG_W(CFG_W), .SPR_W(SPR_W), .EXP_W(EXP_W),
        .LEG_W(5), .LEG_BASE(16), .MIN_DIV(MIN_DIV), .DIV_W(DIV_W)
    ) u_decode (
        .ext_mode(ext_mode),
        .cfg     (cfg_byte),
        .div     (dec_div),
        .bad     (dec_bad)
    );

    spipre_fsm #(
        .DIV_W(DIV_W), .MIN_DIV(MIN_DIV)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .div_in     (dec_div),
        .bad_in     (dec_bad),
        .tick       (sclk_tick),
        .invalid    (cfg_invalid)
    );
endmodule

// File: rtl/spi_sclk_prescaler_chk.sv
module spi_sclk_prescaler_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_active,
    input logic sclk_tick,
    input logic cfg_invalid
);
    // R8: an idle sample forbids a strobe on the next cycle
    a_r8_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |=> !sclk_tick);

    // R4: an invalid setting never coexists with a strobe
    a_r4_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |-> !sclk_tick);

    // R5: strobes are never adjacent (half period is at least 2)
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_tick |=> !sclk_tick);

    // R7: the flag is frozen while a transfer continues
    a_r7_frozen_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && $past(xfer_active)) |=> $stable(cfg_invalid));

    // R1: quiet outputs during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!sclk_tick && !cfg_invalid);
        end
    end
endmodule

bind spi_sclk_prescaler spi_sclk_prescaler_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_active(xfer_active),
    .sclk_tick  (sclk_tick),
    .cfg_invalid(cfg_invalid)
);

// File: tb/spi_sclk_prescaler_tb.sv
`timescale 1ns/1ps
module spi_sclk_prescaler_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_active = 1'b0;
    logic       ext_mode = 1'b0;
    logic [7:0] cfg_byte = 8'h12;
    logic       sclk_tick;
    logic       cfg_invalid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    spi_sclk_prescaler dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active),
        .ext_mode(ext_mode), .cfg_byte(cfg_byte),
        .sclk_tick(sclk_tick), .cfg_invalid(cfg_invalid)
    );

    function automatic int exp_div(bit m, logic [7:0] c);
        if (!m) return (c[4:0] >= 5'd16) ? 2 * (int'(c[4:0]) - 16) : 0;
        return int'(c[3:0]) << {c[7:6], c[4]};
    endfunction

    function automatic bit exp_bad(bit m, logic [7:0] c);
        return exp_div(m, c) < 4;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_case(bit m, logic [7:0] c, string tag,
                            bit do_mid, bit mm, logic [7:0] mc);
        int d, h, lo, nt, cap;
        int tpos[4];
        bit bad, chg;
        @(negedge clk);
        xfer_active = 1'b0; ext_mode = m; cfg_byte = c;
        @(posedge clk); @(negedge clk);
        d = exp_div(m, c); bad = exp_bad(m, c);
        check({tag, " R4 flag in idle"}, cfg_invalid, bad);
        xfer_active = 1'b1;
        nt = 0; chg = 1'b0;
        h = (d + 1) / 2; lo = d / 2;
        cap = bad ? 40 : 2 * d + 4;
        for (int n = 1; n <= cap; n++) begin
            @(posedge clk); @(negedge clk);
            if (sclk_tick) begin
                if (nt < 4) tpos[nt] = n - 1;
                nt++;
            end
            if (do_mid && nt == 1 && !chg) begin
                ext_mode = mm; cfg_byte = mc; chg = 1'b1;
            end
            if (nt == 4) break;
        end
        if (bad) begin
            check({tag, " R4 no strobe when invalid"}, nt, 0);
        end else begin
            check({tag, " R5 strobe count"}, nt, 4);
            if (nt == 4) begin
                check({tag, " R5 first strobe"}, tpos[0], h);
                check({tag, " R5/R6 gap short"}, tpos[1] - tpos[0], lo);
                check({tag, " R5/R6 gap long"}, tpos[2] - tpos[1], h);
                check({tag, " R5/R6 second short"}, tpos[3] - tpos[2], lo);
            end
        end
        if (do_mid) check({tag, " R7 flag frozen"}, cfg_invalid, bad);
        xfer_active = 1'b0;
        nt = 0;
        for (int n = 0; n < 6; n++) begin
            @(posedge clk); @(negedge clk);
            if (sclk_tick) nt++;
        end
        check({tag, " R8 quiet after drop"}, nt, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed);
        repeat (3) @(negedge clk);
        check("R1 tick in reset", sclk_tick, 0);
        check("R1 invalid in reset", cfg_invalid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2 compact encoding, bits 7:5 ignored
        run_case(1'b0, 8'h12, "R2 ratio4", 0, 0, 8'h0);
        run_case(1'b0, 8'hF2, "R2 ratio4 upper bits", 0, 0, 8'h0);
        run_case(1'b0, 8'h1F, "R2 ratio30", 0, 0, 8'h0);
        run_case(1'b0, 8'h35, "R2 ratio10 bit5", 0, 0, 8'h0);
        run_case(1'b0, 8'h11, "R4 compact 0x11", 0, 0, 8'h0);
        run_case(1'b0, 8'h05, "R4 compact low", 0, 0, 8'h0);
        // R3 wide encoding, bit 5 ignored
        run_case(1'b1, 8'h05, "R3 ratio5 odd", 0, 0, 8'h0);
        run_case(1'b1, 8'h25, "R3 ratio5 bit5", 0, 0, 8'h0);
        run_case(1'b1, 8'h53, "R3 ratio24", 0, 0, 8'h0);
        run_case(1'b1, 8'h00, "R4 base zero", 0, 0, 8'h0);
        run_case(1'b1, 8'hD0, "R4 base zero exp7", 0, 0, 8'h0);
        // R9 extremes
        run_case(1'b1, 8'hDF, "R9 ratio1920", 0, 0, 8'h0);
        run_case(1'b1, 8'h12, "R9 ratio4 wide", 0, 0, 8'h0);
        run_case(1'b1, 8'h03, "R9 ratio3 invalid", 0, 0, 8'h0);
        // R7 mid-transfer changes
        run_case(1'b0, 8'h13, "R7 valid then change", 1, 1, 8'hC7);
        run_case(1'b1, 8'h07, "R7 odd then invalid", 1, 0, 8'h01);
        run_case(1'b1, 8'h00, "R7 invalid then valid", 1, 0, 8'h14);
        // random mix
        for (int i = 0; i < 25; i++) begin
            bit rm;
            logic [7:0] rc;
            rm = 1'($urandom % 2);
            rc = 8'($urandom % 256);
            run_case(rm, rc, "R2/R3 random", 0, 0, 8'h0);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule